// File: doc/BRIEF.md
# Free-Running-Clock SPI Master

This block is an 8-bit SPI master. Its serial clock comes from a prescaler that counts the bus clock freely. The prescaler is not restarted when the host writes a byte. A write only marks the byte as waiting. The byte goes out at the next bit-time boundary of the prescaler. The delay between the write and the first serial activity therefore depends on where the write lands in the prescaler cycle, and it never exceeds one bit time.

The host picks one of four bit rates, the clock idle level (`cpol`) and the clock phase (`cpha`). The block drives `sck` and `mosi` and samples `miso`. It shows a busy flag, a done flag and the received byte. A write made while a byte is still waiting or moving is dropped, and a sticky collision flag records it. The prescaler and all transfer state are held cleared unless both the enable and the master-select inputs are high.

Top module: `spi_freerun_master`

## Requirements
- R1: After reset, `busy`, `done`, `collision` and `rxData` are 0, and `sck` equals `cpol`.
- R2: While no transfer is in progress, `sck` sits at its idle level: low for `cpol`=0 and high for `cpol`=1.
- R3: A write (`wrEn` high at a rising edge) is accepted only when `enable` and `masterSel` are both high and `busy` is low. After the accepting edge, `busy` is 1 and `done` is 0.
- R4: The rate select `rateSel` = 0, 1, 2, 3 sets a bit time of D = 2, 8, 32 or 128 bus cycles. The prescaler restarts from zero while `enable` and `masterSel` are not both high. Number the first rising edge that samples both of them high as edge 0. Bit boundaries are then the edges k for which k mod D equals D-1.
- R5: A transfer starts at the first bit boundary at or after the accepting edge. This gives a start delay of 0 to D-1 cycles, and the delay is the same for either `cpha`.
- R6: With `cpha`=0, the MSB is on `mosi` from the start, and `sck` holds its idle level for the first D/2 cycles. Its first transition comes D/2 cycles after the start.
- R7: With `cpha`=1, `sck` makes its first transition (idle to active) at the start edge itself, and the MSB drives `mosi` from that edge.
- R8: A transfer has exactly 16 `sck` transitions, spaced D/2 cycles apart. `mosi` carries the written byte MSB first and changes only on the transitions where the receiver does not sample.
- R9: `miso` is sampled on the first transition of each bit time for `cpha`=0 and on the second for `cpha`=1, MSB first. The assembled byte appears on `rxData` when the transfer ends.
- R10: A transfer lasts exactly 8 bit times. `busy` falls and `done` rises 8·D cycles after the start edge, and `sck` is then idle.
- R11: A write made while `busy` is high is ignored: the byte in flight is not changed. The write sets `collision`, which stays set until `enable` or `masterSel` goes low.
- R12: A write made while `enable` or `masterSel` is low has no effect: `busy` stays low, `sck` stays idle and `collision` stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable |
| masterSel | input | 1 | Master mode select |
| rateSel | input | 2 | Bit-rate select (D = 2, 8, 32, 128) |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Serial clock phase |
| wrEn | input | 1 | Data register write strobe |
| wrData | input | 8 | Byte to transmit |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| busy | output | 1 | Byte waiting or in flight |
| done | output | 1 | Last transfer completed |
| collision | output | 1 | Sticky flag for a write made while busy |
| rxData | output | 8 | Last received byte |

## Verification
Each transfer reprograms the rate and mode and restarts the prescaler. The write is then placed at a random offset of up to two bit times into the prescaler cycle. This separates a start aligned to the boundary from a start counted from the write, and it shows whether the first transition of `cpha`=0 lags the start of `cpha`=1 by exactly half a bit. Directed cases cover a write that lands on a boundary edge, the slowest and fastest rates in both phases, and complementary data patterns such as 0x80 against 0x01, which expose bit-order and off-by-one-shift faults. Other directed cases make a second write in the middle of a transfer and make writes while disabled or with master mode cleared. These check that the byte in flight, the collision flag and the idle clock behave as required.

// File: rtl/spim_pkg.sv
package spim_pkg;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic capture;     // accepted host write: hold the byte
    logic load;        // transfer start: fill the transmit shifter
    logic loadDirect;  // start coincides with the write: take the bus byte
    logic shiftOut;    // advance mosi to the next bit
    logic sample;      // shift miso into the receive shifter
    logic finish;      // last half bit done: publish received byte
  } spimStrobe_t;

endpackage

// File: rtl/spim_prescaler.sv
module spim_prescaler #(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic [RATE_W-1:0] rateSel,
  output logic              halfTick,
  output logic              bitTick
);

  // The largest divide is 2 * 4^(2^RATE_W - 1).
  localparam int PRE_W = 1 + 2 * ((1 << RATE_W) - 1);

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] halfMask;
  logic [PRE_W-1:0] bitMask;

  always_comb begin
    halfMask = (PRE_W'(1) << {rateSel, 1'b0}) - PRE_W'(1);
    bitMask  = {halfMask[PRE_W-2:0], 1'b1};
  end

  assign halfTick = run && ((cnt & halfMask) == halfMask);
  assign bitTick  = run && ((cnt & bitMask) == bitMask);

  always_ff @(posedge clk) begin
    if (!rstN)     cnt <= '0;
    else if (!run) cnt <= '0;
    else           cnt <= cnt + PRE_W'(1);
  end

  // R4
  bit_on_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> halfTick);

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        run,
  input  logic        cpha,
  input  logic        wrEn,
  input  logic        halfTick,
  input  logic        bitTick,
  output spimStrobe_t strb,
  output logic        sckPhase,
  output logic        busy,
  output logic        done,
  output logic        collision
);

  localparam int LAST  = 2 * DATA_W;
  localparam int CNT_W = $clog2(LAST + 1);

  logic             pending;
  logic             active;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] nxt;
  logic             accept;
  logic             collide;
  logic             start;
  logic             step;
  logic             atEnd;

  assign busy    = pending | active;
  assign accept  = run && wrEn && !busy;
  assign collide = run && wrEn && busy;
  assign start   = bitTick && !active && (pending || accept);
  assign step    = active && halfTick;
  assign nxt     = phaseCnt + CNT_W'(1);
  assign atEnd   = (nxt == CNT_W'(LAST));

  always_comb begin
    strb            = '0;
    strb.capture    = accept;
    strb.load       = start;
    strb.loadDirect = accept;
    strb.sample     = step && nxt[0];
    strb.shiftOut   = step && !nxt[0] && !atEnd;
    strb.finish     = step && atEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= 1'b0;
      active    <= 1'b0;
      phaseCnt  <= '0;
      sckPhase  <= 1'b0;
      done      <= 1'b0;
      collision <= 1'b0;
    end else if (!run) begin
      pending   <= 1'b0;
      active    <= 1'b0;
      phaseCnt  <= '0;
      sckPhase  <= 1'b0;
      collision <= 1'b0;
    end else begin
      if (collide) collision <= 1'b1;
      if (accept) begin
        done    <= 1'b0;
        pending <= 1'b1;
      end
      if (start) begin
        pending  <= 1'b0;
        active   <= 1'b1;
        phaseCnt <= '0;
        sckPhase <= cpha;
      end else if (step) begin
        phaseCnt <= nxt;
        if (atEnd) begin
          active   <= 1'b0;
          done     <= 1'b1;
          sckPhase <= 1'b0;
        end else begin
          sckPhase <= cpha ? ~nxt[0] : nxt[0];
        end
      end
    end
  end

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (phaseCnt < CNT_W'(LAST)));

  // R11
  collision_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (collision && run) |=> collision);

  // R10
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !busy);

  // R8
  sck_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sckPhase) |-> $past(halfTick || !run));

endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spimStrobe_t       strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData
);

  logic [DATA_W-1:0] txHold;
  logic [DATA_W-1:0] shiftTx;
  logic [DATA_W-1:0] shiftRx;

  assign mosi = shiftTx[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold  <= '0;
      shiftTx <= '0;
      shiftRx <= '0;
      rxData  <= '0;
    end else begin
      if (strb.capture) txHold <= wrData;
      if (strb.load)
        shiftTx <= strb.loadDirect ? wrData : txHold;
      else if (strb.shiftOut)
        shiftTx <= {shiftTx[DATA_W-2:0], 1'b0};
      if (strb.load)
        shiftRx <= '0;
      else if (strb.sample)
        shiftRx <= {shiftRx[DATA_W-2:0], miso};
      if (strb.finish) rxData <= shiftRx;
    end
  end

  // R8
  tx_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(shiftTx) |-> $past(strb.load || strb.shiftOut));

  // R9
  rx_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> $past(strb.finish));

endmodule

// File: rtl/spi_freerun_master.sv
module spi_freerun_master
  import spim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              masterSel,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic              collision,
  output logic [DATA_W-1:0] rxData
);

  logic        run;
  logic        halfTick;
  logic        bitTick;
  logic        sckPhase;
  spimStrobe_t strb;

  assign run = enable && masterSel;
  assign sck = sckPhase ^ cpol;

  spim_prescaler #(.RATE_W(RATE_W)) uPre (
    .clk      (clk),
    .rstN     (rstN),
    .run      (run),
    .rateSel  (rateSel),
    .halfTick (halfTick),
    .bitTick  (bitTick)
  );

  spim_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .run       (run),
    .cpha      (cpha),
    .wrEn      (wrEn),
    .halfTick  (halfTick),
    .bitTick   (bitTick),
    .strb      (strb),
    .sckPhase  (sckPhase),
    .busy      (busy),
    .done      (done),
    .collision (collision)
  );

  spim_datapath #(.DATA_W(DATA_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .miso   (miso),
    .mosi   (mosi),
    .rxData (rxData)
  );

endmodule

// File: tb/tb_spi_freerun_master.sv
module tb_spi_freerun_master;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       masterSel = 1'b0;
  logic [1:0] rateSel = 2'd0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic       miso = 1'b0;
  logic       sck;
  logic       mosi;
  logic       busy;
  logic       done;
  logic       collision;
  logic [7:0] rxData;

  int checks = 0;
  int errors = 0;
  int edgeNum = 0;
  bit prevCollided = 1'b0;

  spi_freerun_master dut (
    .clk(clk), .rstN(rstN), .enable(enable), .masterSel(masterSel),
    .rateSel(rateSel), .cpol(cpol), .cpha(cpha), .wrEn(wrEn),
    .wrData(wrData), .miso(miso), .sck(sck), .mosi(mosi), .busy(busy),
    .done(done), .collision(collision), .rxData(rxData)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) edgeNum <= edgeNum + 1;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int bitTime(input logic [1:0] r);
    return 2 << (2 * r);
  endfunction

  // First boundary edge at or after edge w, boundaries at (k - e0) mod D == D-1.
  function automatic int expStart(input int w, input int e0, input int d);
    int s = w;
    while (((s - e0) % d) != d - 1) s++;
    return s;
  endfunction

  task automatic runXfer(input logic [1:0] r, input logic cp, input logic ch,
                         input logic [7:0] tx, input logic [7:0] sl,
                         input bit doCol, input int waitCyc);
    int d = bitTime(r);
    int e0, w, f, b, s, edges;
    logic prevSck, prevMosi;
    logic [7:0] cap = 8'd0;
    bit first = 1'b1, colPend = 1'b0, colDone = 1'b0;
    f = -1; b = -1; edges = 0;
    @(negedge clk);
    enable = 1'b0; wrEn = 1'b0;
    @(negedge clk);
    if (prevCollided) check("R11 collision clears when disabled", int'(collision), 0);
    rateSel = r; cpol = cp; cpha = ch; miso = sl[7];
    enable = 1'b1; masterSel = 1'b1;
    e0 = edgeNum + 1;
    @(negedge clk);
    check("R2 idle sck level", int'(sck), int'(cp));
    repeat (waitCyc) @(negedge clk);
    wrEn = 1'b1; wrData = tx; w = edgeNum + 1;
    prevSck = cp; prevMosi = mosi;
    for (int guard = 0; guard < 4000; guard++) begin
      @(negedge clk);
      if (first) begin
        wrEn = 1'b0; first = 1'b0;
        check("R3 busy after write", int'(busy), 1);
        check("R3 done cleared by write", int'(done), 0);
      end else if (colPend) begin
        wrEn = 1'b0; colPend = 1'b0;
        check("R11 collision set", int'(collision), 1);
      end
      if (sck !== prevSck) begin
        edges++;
        if (edges == 1) f = edgeNum;
        if (ch ? (edges % 2 == 0) : (edges % 2 == 1)) cap = {cap[6:0], prevMosi};
        if (!ch && (edges % 2 == 0) && edges < 16) miso = sl[7 - edges / 2];
        if (ch && (edges % 2 == 1)) miso = sl[7 - (edges - 1) / 2];
      end
      prevSck = sck; prevMosi = mosi;
      if (doCol && edges == 5 && !colDone) begin
        wrEn = 1'b1; wrData = ~tx; colDone = 1'b1; colPend = 1'b1;
      end
      if (!busy) begin
        b = edgeNum;
        break;
      end
    end
    s = expStart(w, e0, d);
    check(ch ? "R7 first edge at start" : "R6 first edge half bit late",
          f, s + (ch ? 0 : d / 2));
    check("R5 start delay within one bit", int'((s - w) < d), 1);
    check("R10 transfer length 8 bit times", b, s + 8 * d);
    check("R8 sck transition count", edges, 16);
    check("R8 mosi byte MSB first", int'(cap), int'(tx));
    check("R9 received byte", int'(rxData), int'(sl));
    check("R10 done after transfer", int'(done), 1);
    check("R2 sck idle after transfer", int'(sck), int'(cp));
    check("R11 collision flag", int'(collision), int'(doCol));
    prevCollided = doCol;
  endtask

  task automatic disabledWrite(input logic en, input logic ms, input logic cp);
    @(negedge clk);
    enable = 1'b0; masterSel = 1'b0;
    @(negedge clk);
    enable = en; masterSel = ms; cpol = cp;
    wrEn = 1'b1; wrData = 8'hA5;
    @(negedge clk);
    wrEn = 1'b0;
    repeat (300) @(negedge clk);
    check("R12 busy stays low", int'(busy), 0);
    check("R12 sck stays idle", int'(sck), int'(cp));
    check("R12 no collision", int'(collision), 0);
    prevCollided = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy at reset", int'(busy), 0);
    check("R1 done at reset", int'(done), 0);
    check("R1 collision at reset", int'(collision), 0);
    check("R1 rxData at reset", int'(rxData), 0);
    check("R1 sck at reset", int'(sck), 0);
    rstN = 1'b1;
    @(negedge clk);

    runXfer(2'd0, 1'b0, 1'b0, 8'h80, 8'h01, 1'b0, 0);
    runXfer(2'd0, 1'b0, 1'b1, 8'h01, 8'h80, 1'b0, 1);
    runXfer(2'd3, 1'b1, 1'b0, 8'hA5, 8'h3C, 1'b0, 100);
    runXfer(2'd3, 1'b1, 1'b1, 8'h5A, 8'hC3, 1'b0, 0);
    runXfer(2'd1, 1'b0, 1'b0, 8'hF0, 8'h0F, 1'b1, 3);
    runXfer(2'd2, 1'b1, 1'b1, 8'h3C, 8'hA5, 1'b1, 17);
    runXfer(2'd1, 1'b0, 1'b1, 8'hFF, 8'h00, 1'b0, 6);
    disabledWrite(1'b0, 1'b1, 1'b0);
    disabledWrite(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) begin
      logic [1:0] r  = 2'($urandom % 4);
      int         wc = int'($urandom % (2 * bitTime(r)));
      runXfer(r, 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
              ($urandom % 4) == 0, wc);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule